// File: doc/BRIEF.md
# UART Interrupt Status Priority Encoder

This block gathers the interrupt sources of one serial channel and turns them into one status code and one interrupt line. Five sources feed it: a line-error event, a received-data-ready level, a receive-timeout event, a transmit-holding-empty event and a modem-change event. Event sources are latched into pending flags. The received-data-ready source is a live level that the receive FIFO logic drives. Each source class can be enabled or masked. The interrupt line is high whenever an enabled source is pending.

A CPU reads the status register by raising a read strobe. On the first clock edge of the strobe, the code of the highest-priority enabled source is captured into the status register. The register holds that value until the next strobe. Only the transmit-holding-empty source is cleared by this read, and only when it is the source shown. The other sources clear through their own inputs, which the neighbouring register reads and writes pulse. After one source is serviced, the next lower source appears on the following read.

Top module: `uart_irq_status`

## Requirements
- R1: While reset is asserted, the status register reads 000001, all pending flags are cleared, and with no source present the interrupt output is low.
- R2: Line error has the highest priority. When it is pending and enabled, the captured code is 000110 regardless of the other sources.
- R3: Received-data-ready has the next priority and reads 000100. It takes precedence over the timeout code, over transmit-empty and over modem change.
- R4: Receive timeout reads 001100. It is reported when it is the highest enabled pending source.
- R5: Transmit-holding-empty reads 000010 when it is the highest enabled pending source.
- R6: Modem change has the lowest priority and reads 000000. Bits 5:4 of the status register are always 0.
- R7: With no enabled source pending, a read returns 000001 and the interrupt output is low. With any enabled source pending, the interrupt output is high.
- R8: Enable bit 0 masks line error, bit 1 masks both receive sources, bit 2 masks transmit-empty and bit 3 masks modem change. A masked source neither raises the interrupt nor appears in a read.
- R9: A status read whose captured code is 000010 clears the transmit-empty flag, so a lower pending source appears on the next read.
- R10: A status read that shows any other code leaves the transmit-empty flag pending.
- R11: Line error clears only on its clear input, timeout only on the data-read clear, modem change only on the modem-read clear, and transmit-empty also on the holding-register-write clear. Received-data-ready follows its level input.
- R12: The code is captured on the rising edge of the read strobe and held while the strobe stays high, even if sources change. A multi-cycle strobe acts as one read.
- R13: When a flag's set and clear inputs arrive in the same cycle, the flag ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_src | input | 4 | Source enables: [0] line, [1] receive, [2] transmit-empty, [3] modem |
| line_err_set | input | 1 | Line-error event pulse |
| rx_lvl_ready | input | 1 | Receive FIFO at or above trigger level (live level) |
| rx_tmo_set | input | 1 | Receive-timeout event pulse |
| thre_set | input | 1 | Transmit-holding-empty event pulse |
| modem_chg_set | input | 1 | Modem-change event pulse |
| line_rd_clr | input | 1 | Line-status read, clears line error |
| data_rd_clr | input | 1 | Receive data read, clears timeout |
| thr_wr_clr | input | 1 | Holding-register write, clears transmit-empty |
| modem_rd_clr | input | 1 | Modem-status read, clears modem change |
| isr_rd | input | 1 | Status-register read strobe |
| isr_data | output | ISR_W (6) | Captured status code |
| irq | output | 1 | Interrupt request |

## Verification
Errors in the pending flags show on `irq` in the cycle after the event edge, and in the code of the next status read. A flag that is not cleared, or is cleared by mistake, shows as a repeated or a skipped code on the read after the one that should have changed it. The bench therefore runs read chains through several priority levels and compares every captured code against a queue of expected codes. A capture that is not tied to the strobe edge shows as a change of `isr_data` while the strobe is held, which is checked in the middle of a long strobe.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   typedef enum logic [3:0] {
      ID_LINE  = 4'b0110,
      ID_RXRDY = 4'b0100,
      ID_RXTMO = 4'b1100,
      ID_THRE  = 4'b0010,
      ID_MODEM = 4'b0000,
      ID_NONE  = 4'b0001
   } irq_id_e;

   localparam int ID_W      = 4;
   localparam int NUM_FLAGS = 4;
   localparam int FL_LINE   = 0;
   localparam int FL_TMO    = 1;
   localparam int FL_THRE   = 2;
   localparam int FL_MODEM  = 3;

   localparam int NUM_EN    = 4;
   localparam int EN_LINE   = 0;
   localparam int EN_RX     = 1;
   localparam int EN_THRE   = 2;
   localparam int EN_MODEM  = 3;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int N        = 4,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);

   if (N < 1) begin : g_bad_n
      $error("irq_flag_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic nxt;
      if (SET_WINS) begin : g_set_first
         assign nxt = set_i[i] | (pend_o[i] & ~clr_i[i]);
      end else begin : g_clr_first
         assign nxt = ~clr_i[i] & (pend_o[i] | set_i[i]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_o[i] <= 1'b0;
         else        pend_o[i] <= nxt;
      end
   end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
   import uart_irq_pkg::*;
(
   input  logic    line_i,
   input  logic    rxrdy_i,
   input  logic    tmo_i,
   input  logic    thre_i,
   input  logic    modem_i,
   output irq_id_e id_o,
   output logic    any_o
);

   always_comb begin
      if (line_i)       id_o = ID_LINE;
      else if (rxrdy_i) id_o = ID_RXRDY;
      else if (tmo_i)   id_o = ID_RXTMO;
      else if (thre_i)  id_o = ID_THRE;
      else if (modem_i) id_o = ID_MODEM;
      else              id_o = ID_NONE;
   end

   assign any_o = line_i | rxrdy_i | tmo_i | thre_i | modem_i;

endmodule

// File: rtl/isr_capture.sv
module isr_capture #(
   parameter int               W         = 6,
   parameter logic [W-1:0]     RST_VALUE = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd_i,
   input  logic [W-1:0] code_i,
   output logic         rd_rise_o,
   output logic [W-1:0] q_o
);

   logic rd_d;

   assign rd_rise_o = rd_i & ~rd_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_d <= 1'b0;
         q_o  <= RST_VALUE;
      end else begin
         rd_d <= rd_i;
         if (rd_rise_o) q_o <= code_i;
      end
   end

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
   import uart_irq_pkg::*;
#(
   parameter int ISR_W    = 6,
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       en_src,
   input  logic             line_err_set,
   input  logic             rx_lvl_ready,
   input  logic             rx_tmo_set,
   input  logic             thre_set,
   input  logic             modem_chg_set,
   input  logic             line_rd_clr,
   input  logic             data_rd_clr,
   input  logic             thr_wr_clr,
   input  logic             modem_rd_clr,
   input  logic             isr_rd,
   output logic [ISR_W-1:0] isr_data,
   output logic             irq
);

   localparam int PAD_W = ISR_W - ID_W;
   localparam logic [ISR_W-1:0] IDLE_CODE = ISR_W'(ID_NONE);

   if (ISR_W < ID_W) begin : g_bad_w
      $error("uart_irq_status: ISR_W must be at least 4");
   end

   logic [NUM_FLAGS-1:0] set_v, clr_v, pend_v;
   logic                 act_line, act_rx, act_tmo, act_thre, act_modem;
   irq_id_e              cur_id;
   logic [ISR_W-1:0]     cur_code;
   logic                 rd_rise;
   logic                 thre_pend_w, line_act_w;

   always_comb begin
      set_v           = '0;
      set_v[FL_LINE]  = line_err_set;
      set_v[FL_TMO]   = rx_tmo_set;
      set_v[FL_THRE]  = thre_set;
      set_v[FL_MODEM] = modem_chg_set;
   end

   always_comb begin
      clr_v           = '0;
      clr_v[FL_LINE]  = line_rd_clr;
      clr_v[FL_TMO]   = data_rd_clr;
      clr_v[FL_THRE]  = thr_wr_clr | (rd_rise & (cur_id == ID_THRE));
      clr_v[FL_MODEM] = modem_rd_clr;
   end

   irq_flag_bank #(.N(NUM_FLAGS), .SET_WINS(SET_WINS)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v),
      .clr_i  (clr_v),
      .pend_o (pend_v)
   );

   assign act_line  = pend_v[FL_LINE]  & en_src[EN_LINE];
   assign act_rx    = rx_lvl_ready     & en_src[EN_RX];
   assign act_tmo   = pend_v[FL_TMO]   & en_src[EN_RX];
   assign act_thre  = pend_v[FL_THRE]  & en_src[EN_THRE];
   assign act_modem = pend_v[FL_MODEM] & en_src[EN_MODEM];

   irq_prio_enc u_enc (
      .line_i  (act_line),
      .rxrdy_i (act_rx),
      .tmo_i   (act_tmo),
      .thre_i  (act_thre),
      .modem_i (act_modem),
      .id_o    (cur_id),
      .any_o   (irq)
   );

   if (PAD_W == 0) begin : g_no_pad
      assign cur_code = cur_id;
   end else begin : g_pad
      assign cur_code = {{PAD_W{1'b0}}, cur_id};
   end

   isr_capture #(.W(ISR_W), .RST_VALUE(IDLE_CODE)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_i      (isr_rd),
      .code_i    (cur_code),
      .rd_rise_o (rd_rise),
      .q_o       (isr_data)
   );

   assign thre_pend_w = pend_v[FL_THRE];
   assign line_act_w  = act_line;

endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk #(
   parameter int ISR_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             isr_rd,
   input logic [3:0]       en_src,
   input logic             irq,
   input logic [ISR_W-1:0] isr_data,
   input logic             thre_set,
   input logic             thre_pend,
   input logic             line_act
);

   // R1
   rst_idle_chk: assert property (@(posedge clk)
      !rst_n |=> isr_data == ISR_W'(4'b0001));

   // R2
   line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isr_rd) && line_act |=> isr_data[3:0] == 4'b0110);

   // R6
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (isr_data >> 4) == '0);

   // R7
   idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isr_rd) && !irq |=> isr_data[3:0] == 4'b0001);

   // R7
   busy_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isr_rd) && irq |=> isr_data[3:0] != 4'b0001);

   // R8
   line_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isr_rd) && !en_src[0] |=> isr_data[3:0] != 4'b0110);

   // R9
   thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isr_rd) && !thre_set |=> (isr_data[3:0] != 4'b0010) || !thre_pend);

   // R12
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(isr_rd) |=> $stable(isr_data));

endmodule

bind uart_irq_status uart_irq_status_chk #(.ISR_W(ISR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .isr_rd    (isr_rd),
   .en_src    (en_src),
   .irq       (irq),
   .isr_data  (isr_data),
   .thre_set  (thre_set),
   .thre_pend (thre_pend_w),
   .line_act  (line_act_w)
);

// File: tb/tb_uart_irq_status.sv
module tb_uart_irq_status;

   localparam logic [5:0] C_LINE  = 6'b000110;
   localparam logic [5:0] C_RXRDY = 6'b000100;
   localparam logic [5:0] C_RXTMO = 6'b001100;
   localparam logic [5:0] C_THRE  = 6'b000010;
   localparam logic [5:0] C_MODEM = 6'b000000;
   localparam logic [5:0] C_NONE  = 6'b000001;

   // set mask bits: [0] line, [1] timeout, [2] thre, [3] modem
   // clear mask bits: [0] line read, [1] data read, [2] holding write, [3] modem read
   localparam logic [3:0] S_LINE = 4'b0001, S_TMO = 4'b0010, S_THRE = 4'b0100, S_MOD = 4'b1000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] en_src = 4'b1111;
   logic       line_err_set = 0, rx_lvl_ready = 0, rx_tmo_set = 0, thre_set = 0, modem_chg_set = 0;
   logic       line_rd_clr = 0, data_rd_clr = 0, thr_wr_clr = 0, modem_rd_clr = 0;
   logic       isr_rd = 0;
   logic [5:0] isr_data;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [5:0] exp_q[$];
   string      tag_q[$];
   logic       h1 = 0, h2 = 0;

   always #2 clk = ~clk;

   uart_irq_status dut (
      .clk(clk), .rst_n(rst_n), .en_src(en_src),
      .line_err_set(line_err_set), .rx_lvl_ready(rx_lvl_ready), .rx_tmo_set(rx_tmo_set),
      .thre_set(thre_set), .modem_chg_set(modem_chg_set),
      .line_rd_clr(line_rd_clr), .data_rd_clr(data_rd_clr),
      .thr_wr_clr(thr_wr_clr), .modem_rd_clr(modem_rd_clr),
      .isr_rd(isr_rd), .isr_data(isr_data), .irq(irq)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic chk_irq(input string tag, input logic exp);
      @(negedge clk);
      checks++;
      if (irq !== exp) begin
         errors++;
         $display("FAIL %s: irq actual %b expected %b", tag, irq, exp);
      end
   endtask

   // monitor: a capture happens when the strobe was low two negedges ago and high one negedge ago
   always @(negedge clk) begin
      if (h1 && !h2) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: unexpected read, actual %b expected none", isr_data);
         end else begin
            logic [5:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (isr_data !== e) begin
               errors++;
               $display("FAIL %s: read actual %b expected %b", t, isr_data, e);
            end
         end
      end
      h2 = h1;
      h1 = isr_rd;
   end

   task automatic drv(input logic [3:0] s, input logic [3:0] c);
      line_err_set = s[0]; rx_tmo_set = s[1]; thre_set = s[2]; modem_chg_set = s[3];
      line_rd_clr = c[0]; data_rd_clr = c[1]; thr_wr_clr = c[2]; modem_rd_clr = c[3];
      step();
      line_err_set = 0; rx_tmo_set = 0; thre_set = 0; modem_chg_set = 0;
      line_rd_clr = 0; data_rd_clr = 0; thr_wr_clr = 0; modem_rd_clr = 0;
   endtask

   task automatic rd_isr(input logic [5:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      isr_rd = 1;
      step();
      isr_rd = 0;
      step();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      step(); step();
      @(negedge clk);
      chk("R1 reset code", isr_data, C_NONE);
      chk_irq("R1 reset irq", 1'b0);
      rst_n = 1;
      step();

      rd_isr(C_NONE, "R7 idle read");
      chk_irq("R7 idle irq", 1'b0);

      // modem change
      drv(S_MOD, 4'b0);
      chk_irq("R7 irq on modem", 1'b1);
      rd_isr(C_MODEM, "R6 modem code");
      rd_isr(C_MODEM, "R11 modem kept after status read");
      drv(4'b0, 4'b1000);
      rd_isr(C_NONE, "R11 modem cleared by modem read");
      chk_irq("R11 irq low after modem clear", 1'b0);

      // transmit-empty cleared by status read
      drv(S_THRE, 4'b0);
      rd_isr(C_THRE, "R5 thre code");
      rd_isr(C_NONE, "R9 thre cleared by read");

      // lower source appears after thre serviced
      drv(S_THRE | S_MOD, 4'b0);
      rd_isr(C_THRE, "R5 thre over modem");
      rd_isr(C_MODEM, "R9 modem after thre read");
      drv(4'b0, 4'b1000);

      // timeout
      drv(S_TMO, 4'b0);
      rd_isr(C_RXTMO, "R4 timeout code");
      rd_isr(C_RXTMO, "R11 timeout kept after status read");
      drv(4'b0, 4'b0010);
      rd_isr(C_NONE, "R11 timeout cleared by data read");

      // data ready over timeout
      drv(S_TMO, 4'b0);
      rx_lvl_ready = 1;
      rd_isr(C_RXRDY, "R3 data ready over timeout");
      rx_lvl_ready = 0;
      rd_isr(C_RXTMO, "R3 timeout after level drops");
      drv(4'b0, 4'b0010);

      // line error over everything; thre not cleared while line shown
      drv(S_LINE | S_THRE, 4'b0);
      rx_lvl_ready = 1;
      rd_isr(C_LINE, "R2 line over all");
      rd_isr(C_LINE, "R11 line kept after status read");
      drv(4'b0, 4'b0001);
      rx_lvl_ready = 0;
      rd_isr(C_THRE, "R10 thre still pending");
      rd_isr(C_NONE, "R9 thre cleared after shown");

      // masking
      en_src = 4'b1110;
      drv(S_LINE, 4'b0);
      chk_irq("R8 masked line irq", 1'b0);
      rd_isr(C_NONE, "R8 masked line read");
      en_src = 4'b1111;
      rd_isr(C_LINE, "R8 line shows when unmasked");
      drv(4'b0, 4'b0001);
      en_src = 4'b1101;
      rx_lvl_ready = 1;
      chk_irq("R8 masked receive irq", 1'b0);
      rd_isr(C_NONE, "R8 masked receive read");
      rx_lvl_ready = 0;
      en_src = 4'b1111;

      // long strobe: captured once, held while sources change
      drv(S_THRE, 4'b0);
      exp_q.push_back(C_THRE);
      tag_q.push_back("R12 long strobe capture");
      isr_rd = 1;
      step();
      drv(S_LINE, 4'b0);
      @(negedge clk);
      chk("R12 held during strobe", isr_data, C_THRE);
      step();
      isr_rd = 0;
      step();
      rd_isr(C_LINE, "R12 new source on next read");
      drv(4'b0, 4'b0001);
      rd_isr(C_NONE, "R12 thre cleared once by long strobe");

      // holding-register write clears thre
      drv(S_THRE, 4'b0);
      drv(4'b0, 4'b0100);
      rd_isr(C_NONE, "R11 thre cleared by holding write");

      // set and clear in same cycle
      drv(S_THRE, 4'b0100);
      rd_isr(C_THRE, "R13 thre set wins");
      drv(S_LINE, 4'b0001);
      rd_isr(C_LINE, "R13 line set wins");
      drv(4'b0, 4'b0001);
      rd_isr(C_NONE, "R13 final idle");

      step(); step();
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard drain: actual %0d left expected 0", exp_q.size());
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule